// File: doc/BRIEF.md
# Cascadable Priority Interrupt Controller

The block collects up to eight interrupt inputs, remembers which ones have raised a request, and presents the most urgent unmasked one to a processor through a single interrupt line. Software talks to it through a byte-wide register port with two addresses. The low address takes commands and returns either the request register, the in-service register or a poll result. The high address holds the mask register and also receives the follow-on words of the initialization sequence.

Acknowledge happens only through polling. Software arms a poll with a command, and the following low-address read returns the winning input number with a valid flag. The same read marks that input in service. Priority is fixed, with input 0 the most urgent. While an input is in service, inputs of equal or lower urgency are held back until software retires it with a specific end-of-interrupt command. Two instances can be chained as a master and a slave. The initialization sequence tells each instance its place in the chain: a bitmap of slave-carrying inputs for a master, or an identity number for a slave. A request that goes away before the poll is reported as input 7 with the valid flag clear, and it leaves no in-service bit behind.

Top module: `cascade_pic`

## Requirements
- R1: After reset the mask register is 0xFF, the in-service and request registers are 0, the low-address read returns the request register (0x00), no poll is armed and `irq_out` is 0.
- R2: A low-address write with bit 4 set starts initialization. The next high-address write is the vector base. Next comes the chain word, which is skipped when bit 1 of the start word is 1. Last comes the mode word, expected only when bit 0 of the start word is 1. High-address writes that belong to this sequence leave the mask register unchanged.
- R3: The chain word is stored. With `slave_sel`=0, `casc_map` equals the stored bitmap. With `slave_sel`=1, `casc_map` is a one-hot value with the bit set at the identity held in bits 2:0 of the word.
- R4: A high-address write outside initialization loads the mask register, and a high-address read returns it. A mask bit of 1 keeps that input from raising `irq_out` or winning a poll.
- R5: A request bit is set by a rising edge on its input. It stays set while the input stays high, and it clears when the input falls or when the input is acknowledged by a poll.
- R6: Command 0x0B makes later low-address reads return the in-service register. Command 0x0A makes them return the request register. The selection persists across reads.
- R7: Command 0x0C arms a poll. The next low-address read returns bit 7 = 1 and the winner number in bits 2:0. It sets that input's in-service bit, clears its request bit, and disarms the poll.
- R8: An input can win only when it is unmasked and requesting, and no in-service bit at its own or a more urgent (lower-numbered) position is set. Among such inputs the lowest number wins.
- R9: `irq_out` is 1 exactly when some input can win under R8. It changes on the clock edge after an input edge.
- R10: Command 0x60+n clears in-service bit n and leaves the other in-service bits unchanged.
- R11: A poll read with no possible winner returns 0x07 (bit 7 clear, code 7) and leaves the in-service register unchanged. This covers a request on input 7 that is withdrawn before the poll.
- R12: The start word also clears the in-service and request registers, selects the request register for reads, and disarms any pending poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; side effects take place at the clock edge |
| addr | input | 1 | 0 = command / status port, 1 = mask / initialization data port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current address (combinational) |
| irq_in | input | NUM_IN | Interrupt inputs, edge-triggered with level hold |
| slave_sel | input | 1 | 1 when this instance is the slave of a chained pair |
| irq_out | output | 1 | Interrupt request towards the processor or the master |
| casc_map | output | NUM_IN | Chain position: slave bitmap (master) or one-hot identity (slave) |

## Verification
The bench builds the controller with the default of eight inputs. At that width the poll code fills all three bits, and input 7 is both the least urgent input and the spurious report code, so one test drives a withdrawn request on that input against a genuine report. Because eight inputs span the whole byte, the mask and in-service readbacks cover every bit position. Nesting is checked with three inputs active at once, and the chain word is checked in both master and slave readings.

// File: rtl/cpic_pkg.sv
package cpic_pkg;
    localparam int BUS_W = 8;

    typedef enum logic [1:0] {
        PH_RUN  = 2'd0,
        PH_BASE = 2'd1,
        PH_LINK = 2'd2,
        PH_MODE = 2'd3
    } init_phase_e;

    localparam logic [2:0] EOI_SPECIFIC = 3'b011;
endpackage

// File: rtl/cpic_edge.sv
module cpic_edge #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_i,
    output logic [WIDTH-1:0] rise_o
);
    logic [WIDTH-1:0] prev_d, prev_q;

    always_comb prev_d = level_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign rise_o[i] = level_i[i] & ~prev_q[i];
        end
    endgenerate
endmodule

// File: rtl/cpic_prio.sv
module cpic_prio #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0]         req_i,
    input  logic [WIDTH-1:0]         isr_i,
    output logic                     any_o,
    output logic [$clog2(WIDTH)-1:0] code_o
);
    localparam int IDW = $clog2(WIDTH);

    logic [WIDTH-1:0] ceil_ok;
    logic [WIDTH-1:0] cand;

    // an in-service bit at j holds back every input at j and above
    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_ceil
            assign ceil_ok[i] = ~|isr_i[i:0];
        end
    endgenerate

    assign cand  = req_i & ceil_ok;
    assign any_o = |cand;

    // lowest index wins; no candidate reports the last input
    always_comb begin
        code_o = IDW'(WIDTH - 1);
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (cand[i]) code_o = IDW'(i);
        end
    end
endmodule

// File: rtl/cascade_pic.sv
module cascade_pic
    import cpic_pkg::*;
#(
    parameter int NUM_IN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    input  logic [NUM_IN-1:0] irq_in,
    input  logic              slave_sel,
    output logic              irq_out,
    output logic [NUM_IN-1:0] casc_map
);
    localparam int IDW = $clog2(NUM_IN);

    typedef struct packed {
        init_phase_e       phase;
        logic              want_link;
        logic              want_mode;
        logic [NUM_IN-1:0] imr;
        logic [NUM_IN-1:0] isr;
        logic [NUM_IN-1:0] irr;
        logic [NUM_IN-1:0] link;
        logic              show_isr;
        logic              poll_armed;
    } pic_state_t;

    pic_state_t st_d, st_q;

    logic [NUM_IN-1:0] rise;
    logic [NUM_IN-1:0] live_req;
    logic              win_any;
    logic [IDW-1:0]    win_code;
    logic              cmd_wr, dat_wr, cmd_rd;
    logic [BUS_W-1:0]  poll_word;

    cpic_edge #(.WIDTH(NUM_IN)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (irq_in),
        .rise_o  (rise)
    );

    assign live_req = st_q.irr & irq_in & ~st_q.imr;

    cpic_prio #(.WIDTH(NUM_IN)) u_prio (
        .req_i  (live_req),
        .isr_i  (st_q.isr),
        .any_o  (win_any),
        .code_o (win_code)
    );

    assign cmd_wr = wr_en && !addr;
    assign dat_wr = wr_en && addr;
    assign cmd_rd = rd_en && !addr;

    always_comb begin
        st_d = st_q;
        st_d.irr = (st_q.irr | rise) & irq_in;

        if (cmd_rd && st_q.poll_armed) begin
            st_d.poll_armed = 1'b0;
            if (win_any) begin
                st_d.isr[win_code] = 1'b1;
                st_d.irr[win_code] = 1'b0;
            end
        end

        if (cmd_wr) begin
            if (wdata[4]) begin
                st_d.phase      = PH_BASE;
                st_d.want_link  = !wdata[1];
                st_d.want_mode  = wdata[0];
                st_d.isr        = '0;
                st_d.irr        = '0;
                st_d.show_isr   = 1'b0;
                st_d.poll_armed = 1'b0;
            end else if (wdata[3]) begin
                if (wdata[2]) st_d.poll_armed = 1'b1;
                if (wdata[1]) st_d.show_isr   = wdata[0];
            end else if (wdata[7:5] == EOI_SPECIFIC) begin
                st_d.isr[wdata[IDW-1:0]] = 1'b0;
            end
        end

        if (dat_wr) begin
            unique case (st_q.phase)
                PH_RUN:  st_d.imr = wdata[NUM_IN-1:0];
                PH_BASE: st_d.phase = st_q.want_link ? PH_LINK
                                    : (st_q.want_mode ? PH_MODE : PH_RUN);
                PH_LINK: begin
                    st_d.link  = wdata[NUM_IN-1:0];
                    st_d.phase = st_q.want_mode ? PH_MODE : PH_RUN;
                end
                PH_MODE: st_d.phase = PH_RUN;
                default: st_d.phase = PH_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.imr <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        poll_word            = '0;
        poll_word[BUS_W-1]   = win_any;
        poll_word[IDW-1:0]   = win_code;
        if (addr)                 rdata = BUS_W'(st_q.imr);
        else if (st_q.poll_armed) rdata = poll_word;
        else if (st_q.show_isr)   rdata = BUS_W'(st_q.isr);
        else                      rdata = BUS_W'(st_q.irr);
    end

    assign irq_out  = win_any;
    assign casc_map = slave_sel ? ({{(NUM_IN-1){1'b0}}, 1'b1} << st_q.link[IDW-1:0])
                                : st_q.link;

    // specific end-of-interrupt retires the named level
    assert_eoi_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !wdata[4] && !wdata[3] && wdata[7:5] == EOI_SPECIFIC)
        |=> !st_q.isr[$past(wdata[IDW-1:0])]);

    // a valid poll read puts its winner in service
    assert_poll_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rd && st_q.poll_armed && win_any && !wr_en)
        |=> st_q.isr[$past(win_code)]);

    // a poll with no winner leaves the in-service register alone
    assert_spurious_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rd && st_q.poll_armed && !win_any && !wr_en)
        |=> $stable(st_q.isr));

    // initialization words never land in the mask
    assert_init_keeps_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && st_q.phase != PH_RUN) |=> $stable(st_q.imr));

    // a fully masked controller stays silent
    assert_masked_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.imr == '1) |-> !irq_out);
endmodule

// File: tb/tb_cascade_pic.sv
module tb_cascade_pic;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] irq_in = 8'h00;
    logic       slave_sel = 1'b0;
    logic       irq_out;
    logic [7:0] casc_map;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    cascade_pic #(.NUM_IN(8)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq_in(irq_in), .slave_sel(slave_sel),
        .irq_out(irq_out), .casc_map(casc_map)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        tick();
        rd_en = 1'b0;
    endtask

    task automatic set_in(input logic [7:0] v);
        irq_in = v;
        tick();
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(1'b1, d); chk("R1 mask after reset", d, 8'hFF);
        rd(1'b0, d); chk("R1 request after reset", d, 8'h00);
        chk("R1 irq_out after reset", {7'd0, irq_out}, 8'h00);
    endtask

    task automatic t_init_master();
        logic [7:0] d;
        slave_sel = 1'b0;
        wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
        rd(1'b1, d); chk("R2 mask untouched by init words", d, 8'hFF);
        chk("R3 master chain bitmap", casc_map, 8'h04);
    endtask

    task automatic t_init_slave();
        logic [7:0] d;
        slave_sel = 1'b1;
        wr(1'b0, 8'h11); wr(1'b1, 8'h28); wr(1'b1, 8'h02); wr(1'b1, 8'h01);
        chk("R3 slave identity one-hot", casc_map, 8'h04);
        // start word without chain word: base, mode, then mask
        wr(1'b0, 8'h13); wr(1'b1, 8'h30); wr(1'b1, 8'h01); wr(1'b1, 8'h5A);
        rd(1'b1, d); chk("R2 chain word skipped, mask loaded", d, 8'h5A);
        chk("R3 chain word kept when skipped", casc_map, 8'h04);
        slave_sel = 1'b0;
        wr(1'b1, 8'h00);
    endtask

    task automatic t_mask_and_request();
        logic [7:0] d;
        wr(1'b1, 8'h08);
        set_in(8'h08);
        chk("R4 masked input silent", {7'd0, irq_out}, 8'h00);
        wr(1'b1, 8'h00);
        rd(1'b1, d); chk("R4 mask readback", d, 8'h00);
        chk("R9 unmasked request raises irq_out", {7'd0, irq_out}, 8'h01);
        wr(1'b0, 8'h0A);
        rd(1'b0, d); chk("R5 request bit latched", d, 8'h08);
        rd(1'b0, d); chk("R6 selection persists", d, 8'h08);
        set_in(8'h00);
        rd(1'b0, d); chk("R5 request clears when input falls", d, 8'h00);
        chk("R9 irq_out drops with request", {7'd0, irq_out}, 8'h00);
    endtask

    task automatic t_priority_nesting();
        logic [7:0] d;
        set_in(8'h22);
        wr(1'b0, 8'h0C);
        rd(1'b0, d); chk("R7 poll picks input 1", d, 8'h81);
        wr(1'b0, 8'h0B);
        rd(1'b0, d); chk("R6 in-service after poll", d, 8'h02);
        chk("R8 lower urgency held back", {7'd0, irq_out}, 8'h00);
        wr(1'b0, 8'h0C);
        rd(1'b0, d); chk("R8 blocked poll reports nothing", d, 8'h07);
        set_in(8'h23);
        chk("R8 more urgent input nests", {7'd0, irq_out}, 8'h01);
        wr(1'b0, 8'h0C);
        rd(1'b0, d); chk("R7 poll picks input 0", d, 8'h80);
        rd(1'b0, d); chk("R7 both levels in service", d, 8'h03);
        wr(1'b0, 8'h61);
        rd(1'b0, d); chk("R10 only level 1 retired", d, 8'h01);
        wr(1'b0, 8'h60);
        chk("R9 input 5 now eligible", {7'd0, irq_out}, 8'h01);
        wr(1'b0, 8'h0C);
        rd(1'b0, d); chk("R7 poll picks input 5", d, 8'h85);
        wr(1'b0, 8'h0A);
        rd(1'b0, d); chk("R5 acknowledged requests cleared", d, 8'h00);
        wr(1'b0, 8'h65);
        wr(1'b0, 8'h0B);
        rd(1'b0, d); chk("R10 level 5 retired", d, 8'h00);
        set_in(8'h00);
    endtask

    task automatic t_spurious();
        logic [7:0] d;
        set_in(8'h80);
        chk("R9 input 7 raises irq_out", {7'd0, irq_out}, 8'h01);
        set_in(8'h00);
        chk("R11 withdrawn request drops irq_out", {7'd0, irq_out}, 8'h00);
        wr(1'b0, 8'h0C);
        rd(1'b0, d); chk("R11 spurious poll word", d, 8'h07);
        rd(1'b0, d); chk("R11 in-service bit 7 clear", d, 8'h00);
        set_in(8'h80);
        wr(1'b0, 8'h0C);
        rd(1'b0, d); chk("R7 genuine input 7 report", d, 8'h87);
        rd(1'b0, d); chk("R7 in-service bit 7 set", d, 8'h80);
        set_in(8'h00);
    endtask

    task automatic t_reinit();
        logic [7:0] d;
        wr(1'b0, 8'h0C);
        wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
        rd(1'b0, d); chk("R12 poll disarmed, request selected", d, 8'h00);
        wr(1'b0, 8'h0B);
        rd(1'b0, d); chk("R12 in-service cleared", d, 8'h00);
    endtask

    initial begin
        #200000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_init_master();
        t_init_slave();
        t_mask_and_request();
        t_priority_nesting();
        t_spurious();
        t_reinit();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule